// File: doc/BRIEF.md
# Maskable priority interrupt controller

This block is the interrupt front end for a small 8-bit processor core. It collects fifteen request sources into fourteen vector slots: a software break request, six external pins with a selectable active edge, and eight single-cycle internal peripheral events. One slot is shared between the last external pin and the last internal event, and a select bit decides which of the two drives it. Each maskable slot has a request bit and an enable bit, and a global disable flag masks all of them. The break slot ignores every mask.

The block registers the highest-priority candidate into a request line and a 4-bit vector index, and holds both steady until the core answers with a one-cycle accept pulse. Accepting clears the request of the accepted slot and raises the disable flag in the same clock. A dedicated input lets the core lower the flag again, as a return from an interrupt would. Software reaches the request, enable and configuration state through a small word-wide register port.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all request bits, enable bits, edge selects and the source select are 0, the disable flag is 1, and irq_valid is 0.
- R2: A maskable slot (1 to 13) is signalled only while its request bit, its enable bit and the negated disable flag are all 1. Enable register at address 1 holds slots 13..1 in bits 13..1, and bit 0 reads 0.
- R3: Request register at address 0 shows slot n in bit n. Writing a 0 to bit n (n from 1 to 13) clears that request, writing a 1 has no effect, and bit 0 ignores writes. Enable bits can be written to 1 and to 0.
- R4: The break request (brk_req pulse) sets slot 0, which is signalled with vector 0 whatever the enable bits and the disable flag are.
- R5: Among candidates the lowest slot number wins and appears on irq_vec.
- R6: An accept pulse while irq_valid is 1 clears the request of the slot on irq_vec and sets the disable flag (status register, address 3, bit 0) in the same clock edge.
- R7: External pin k passes a two-flop synchronizer; edge select bit k (configuration register, address 2, bits 5..0) picks rising (1) or falling (0). Pins 0..4 set slots 1..5.
- R8: Changing an edge select bit so that the pin's present level becomes the active level sets that pin's request, exactly as an edge would.
- R9: Slot 6 is driven by pin 5 when the source select (address 2, bit 8) is 0 and by internal event 7 when it is 1; the other source is ignored. Writing a different select value sets slot 6.
- R10: While irq_valid is 1 and no accept arrives, irq_valid stays 1 and irq_vec stays unchanged, even if a higher-priority request appears.
- R11: A flag_clr pulse clears the disable flag; a pending enabled request raises irq_valid one cycle after the flag has cleared. A write to address 3 loads bit 0 into the flag.
- R12: An internal event pulse on int_evt[j], j from 0 to 6, sets slot 7+j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_in | input | 6 | Asynchronous external request pins |
| int_evt | input | 8 | Single-cycle internal event pulses |
| brk_req | input | 1 | Software break request pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| irq_valid | output | 1 | Interrupt request to the core |
| irq_vec | output | 4 | Vector slot of the request |
| irq_accept | input | 1 | One-cycle accept pulse from the core |
| flag_clr | input | 1 | Clears the global disable flag |

## Verification
The hold and accept properties take for granted that the core pulses irq_accept only while irq_valid is 1, that internal events and break requests are single-cycle pulses, and that external pins stay at each level for more than two clocks. The stimulus respects this by loading requests while the disable flag is set, lowering the flag only when it wants a decision, and accepting only a request it has seen. External pins and edge selects are changed one step at a time with a settling gap of four cycles before any register is read back.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NUM_EXT     = 6;
    localparam int NUM_INT     = 8;
    localparam int NUM_SLOT    = NUM_EXT + NUM_INT;   // break slot plus 13 maskable slots
    localparam int VEC_W       = $clog2(NUM_SLOT);
    localparam int DATA_W      = 16;
    localparam int ADDR_W      = 2;
    localparam int SHARED_SLOT = NUM_EXT;              // slot driven by last pin or last event
    localparam int SEL_BIT     = 8;

    localparam logic [ADDR_W-1:0] A_REQ  = 2'd0;
    localparam logic [ADDR_W-1:0] A_EN   = 2'd1;
    localparam logic [ADDR_W-1:0] A_CFG  = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

    typedef struct packed {
        logic               flag;
        logic [NUM_EXT-1:0] pol;
        logic               sel;
        logic               valid;
        logic [VEC_W-1:0]   vec;
    } ctrl_st_t;
endpackage

// File: rtl/irqc_edge_det.sv
module irqc_edge_det #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] pol,
    output logic [N-1:0] hit
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] lvl;
    } edge_st_t;

    edge_st_t     st_d, st_q;
    logic [N-1:0] act_lvl;

    always_comb begin
        act_lvl  = ~(st_q.s2 ^ pol);
        hit      = act_lvl & ~st_q.lvl;
        st_d.s1  = pin;
        st_d.s2  = st_q.s1;
        st_d.lvl = act_lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.s1  <= '0;
            st_q.s2  <= '0;
            st_q.lvl <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |-> (($past(st_q.s2[g]) != st_q.s2[g]) || ($past(pol[g]) != pol[g]))); // R8
    end
endmodule

// File: rtl/irqc_req_bank.sv
module irqc_req_bank #(
    parameter int N  = 14,
    parameter int VW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  set_evt,
    input  logic          clr_wr,
    input  logic [N-1:0]  clr_keep,
    input  logic          en_wr,
    input  logic [N-1:0]  en_data,
    input  logic          acc_valid,
    input  logic [VW-1:0] acc_idx,
    output logic [N-1:0]  req_q,
    output logic [N-1:0]  en_q
);
    typedef struct packed {
        logic [N-1:0] req;
        logic [N-1:0] en;
    } bank_st_t;

    localparam logic [N-1:0] BRK_BIT = N'(1);

    bank_st_t     st_d, st_q;
    logic [N-1:0] acc_mask;
    logic [N-1:0] sw_keep;

    always_comb begin
        acc_mask = acc_valid ? (BRK_BIT << acc_idx) : '0;
        sw_keep  = clr_wr ? (clr_keep | BRK_BIT) : '1;
        st_d.req = (st_q.req & ~acc_mask & sw_keep) | set_evt;
        st_d.en  = en_wr ? (en_data & ~BRK_BIT) : st_q.en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_q = st_q.req;
    assign en_q  = st_q.en;

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (!req_q[g] && !set_evt[g]) |=> !req_q[g]); // R3
    end

    AST_ACC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !set_evt[acc_idx]) |=> !req_q[$past(acc_idx)]); // R6
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
    parameter int N  = 14,
    parameter int VW = 4
) (
    input  logic [N-1:0]  cand,
    output logic          any,
    output logic [VW-1:0] idx
);
    logic [N-1:0] below;

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                any = 1'b1;
                idx = VW'(i);
            end
        end
    end

    always_comb begin
        below = (N'(1) << idx) - N'(1);
        AST_PICK_IS_CAND: assert (!any || cand[idx]); // R5
        AST_PICK_IS_TOP: assert (!any || ((cand & below) == '0)); // R5
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EXT-1:0]  ext_in,
    input  logic [NUM_INT-1:0]  int_evt,
    input  logic                brk_req,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq_valid,
    output logic [VEC_W-1:0]    irq_vec,
    input  logic                irq_accept,
    input  logic                flag_clr
);
    ctrl_st_t              st_d, st_q;
    logic [NUM_EXT-1:0]    ext_hit;
    logic [NUM_SLOT-1:0]   set_evt;
    logic [NUM_SLOT-1:0]   slot_req;
    logic [NUM_SLOT-1:0]   slot_en;
    logic [NUM_SLOT-1:0]   cand;
    logic                  pick_any;
    logic [VEC_W-1:0]      pick_idx;
    logic                  wr_req, wr_en, wr_cfg, wr_stat;
    logic                  sel_flip;
    logic                  acc;
    logic                  wdata_unused;

    assign wdata_unused = ^reg_wdata[DATA_W-1:NUM_SLOT];

    always_comb begin
        wr_req   = reg_wr && (reg_addr == A_REQ);
        wr_en    = reg_wr && (reg_addr == A_EN);
        wr_cfg   = reg_wr && (reg_addr == A_CFG);
        wr_stat  = reg_wr && (reg_addr == A_STAT);
        sel_flip = wr_cfg && (reg_wdata[SEL_BIT] != st_q.sel);
        acc      = irq_accept && st_q.valid;
    end

    irqc_edge_det #(.N(NUM_EXT)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_in),
        .pol   (st_q.pol),
        .hit   (ext_hit)
    );

    // Slot map: 0 break, 1..5 pins 0..4, 6 shared, 7..13 events 0..6
    always_comb begin
        set_evt    = '0;
        set_evt[0] = brk_req;
        for (int i = 0; i < NUM_EXT - 1; i++) begin
            set_evt[1 + i] = ext_hit[i];
        end
        for (int j = 0; j < NUM_INT - 1; j++) begin
            set_evt[SHARED_SLOT + 1 + j] = int_evt[j];
        end
        set_evt[SHARED_SLOT] = (st_q.sel ? int_evt[NUM_INT-1] : ext_hit[NUM_EXT-1]) | sel_flip;
    end

    irqc_req_bank #(.N(NUM_SLOT), .VW(VEC_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_evt   (set_evt),
        .clr_wr    (wr_req),
        .clr_keep  (reg_wdata[NUM_SLOT-1:0]),
        .en_wr     (wr_en),
        .en_data   (reg_wdata[NUM_SLOT-1:0]),
        .acc_valid (acc),
        .acc_idx   (st_q.vec),
        .req_q     (slot_req),
        .en_q      (slot_en)
    );

    always_comb begin
        cand    = slot_req & slot_en & {NUM_SLOT{~st_q.flag}};
        cand[0] = slot_req[0];
    end

    irqc_prio_pick #(.N(NUM_SLOT), .VW(VEC_W)) u_pick (
        .cand (cand),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    always_comb begin
        st_d = st_q;
        if (acc) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end else if (wr_stat) begin
            st_d.flag = reg_wdata[0];
        end
        if (wr_cfg) begin
            st_d.pol = reg_wdata[NUM_EXT-1:0];
            st_d.sel = reg_wdata[SEL_BIT];
        end
        if (acc) begin
            st_d.valid = 1'b0;
        end else if (!st_q.valid) begin
            st_d.valid = pick_any;
            st_d.vec   = pick_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flag  <= 1'b1;
            st_q.pol   <= '0;
            st_q.sel   <= 1'b0;
            st_q.valid <= 1'b0;
            st_q.vec   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_REQ:   reg_rdata = DATA_W'(slot_req);
            A_EN:    reg_rdata = DATA_W'(slot_en);
            A_CFG:   begin
                reg_rdata[NUM_EXT-1:0] = st_q.pol;
                reg_rdata[SEL_BIT]     = st_q.sel;
            end
            default: reg_rdata[0] = st_q.flag;
        endcase
    end

    assign irq_valid = st_q.valid;
    assign irq_vec   = st_q.vec;

    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !irq_accept) |=> (irq_valid && $stable(irq_vec))); // R10
    AST_ACC_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_accept) |=> st_q.flag); // R6
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_valid && st_q.flag && !slot_req[0]) |=> !irq_valid); // R2
    AST_BRK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req[0] && !irq_valid) |=> (irq_valid && (irq_vec == '0))); // R4
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
    import irqc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  ext_in = '0;
    logic [7:0]  int_evt = '0;
    logic        brk_req = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_valid;
    logic [3:0]  irq_vec;
    logic        irq_accept = 1'b0;
    logic        flag_clr = 1'b0;

    int total = 0;
    int bad = 0;

    logic [13:0] m_req = '0;
    logic [13:0] m_en = '0;
    bit          m_flag = 1'b1;
    logic [5:0]  m_pol = '0;
    logic [5:0]  m_pins = '0;
    bit          m_sel = 1'b0;

    always #5 clk = ~clk;

    irq_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .int_evt(int_evt),
        .brk_req(brk_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_valid(irq_valid),
        .irq_vec(irq_vec), .irq_accept(irq_accept), .flag_clr(flag_clr)
    );

    task automatic chk(string tag, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit act_lvl(bit pin, bit pol);
        return pin == pol;
    endfunction

    function automatic int win_vec();
        if (m_req[0]) return 0;
        if (m_flag) return -1;
        for (int i = 1; i < 14; i++) if (m_req[i] && m_en[i]) return i;
        return -1;
    endfunction

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic ext_evt(int k);
        if (k < 5) m_req[k+1] = 1'b1;
        else if (!m_sel) m_req[6] = 1'b1;
    endtask

    task automatic w_en(input logic [15:0] d);
        wr(2'd1, d);
        m_en = d[13:0] & 14'h3FFE;
    endtask

    task automatic w_req(input logic [15:0] d);
        wr(2'd0, d);
        m_req[13:1] = m_req[13:1] & d[13:1];
    endtask

    task automatic w_cfg(input logic [5:0] pol, input bit sel);
        logic [5:0] old = m_pol;
        wr(2'd2, {7'd0, sel, 2'd0, pol});
        if (sel != m_sel) m_req[6] = 1'b1;
        m_sel = sel;
        m_pol = pol;
        for (int k = 0; k < 6; k++)
            if (!act_lvl(m_pins[k], old[k]) && act_lvl(m_pins[k], pol[k])) ext_evt(k);
        tick(4);
    endtask

    task automatic set_pins(input logic [5:0] p);
        for (int k = 0; k < 6; k++)
            if (!act_lvl(m_pins[k], m_pol[k]) && act_lvl(p[k], m_pol[k])) ext_evt(k);
        ext_in = p;
        m_pins = p;
        tick(4);
    endtask

    task automatic pulse_int(input logic [7:0] m);
        int_evt = m;
        @(negedge clk);
        int_evt = '0;
        for (int j = 0; j < 7; j++) if (m[j]) m_req[7+j] = 1'b1;
        if (m[7] && m_sel) m_req[6] = 1'b1;
    endtask

    task automatic pulse_brk();
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
        m_req[0] = 1'b1;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        m_flag = 1'b0;
    endtask

    task automatic do_accept(int v);
        irq_accept = 1'b1;
        @(negedge clk);
        irq_accept = 1'b0;
        m_req[v] = 1'b0;
        m_flag = 1'b1;
    endtask

    task automatic check_req(string tag);
        logic [15:0] d;
        rd(2'd0, d);
        chk(tag, int'(d), int'({2'b00, m_req}));
    endtask

    task automatic check_irq(string tag);
        int w = win_vec();
        chk(tag, int'(irq_valid), (w >= 0) ? 1 : 0);
        if (w >= 0) chk(tag, int'(irq_vec), w);
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'd2024));
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd(2'd0, d); chk("R1 req", int'(d), 0);
        rd(2'd1, d); chk("R1 en", int'(d), 0);
        rd(2'd2, d); chk("R1 cfg", int'(d), 0);
        rd(2'd3, d); chk("R1 flag", int'(d), 1);
        chk("R1 valid", int'(irq_valid), 0);

        // R3 writing ones never sets a request, enables read back
        w_req(16'hFFFF); check_req("R3 set-by-write");
        w_en(16'h3FFF); rd(2'd1, d); chk("R3 en readback", int'(d), 16'h3FFE);
        w_en(16'h0000); rd(2'd1, d); chk("R3 en clear", int'(d), 0);

        // R12 internal events
        pulse_int(8'h05); check_req("R12 int event");

        // R2 masked by enable
        pulse_clr(); tick(1);
        chk("R2 disabled slot", int'(irq_valid), 0);
        w_en(16'h0200); tick(1);
        check_irq("R2 enabled slot");
        // R10 hold while higher priority appears
        w_en(16'h3FFE); tick(2);
        chk("R10 vec hold", int'(irq_vec), 9);
        chk("R10 valid hold", int'(irq_valid), 1);
        do_accept(9);
        rd(2'd3, d); chk("R6 flag set", int'(d), 1);
        check_req("R6 req cleared");
        chk("R6 valid drop", int'(irq_valid), 0);

        // R4 break ignores flag
        pulse_brk(); tick(1);
        check_irq("R4 break");
        do_accept(0); tick(1);
        check_req("R4 break cleared");
        chk("R4 idle", int'(irq_valid), 0);

        // R5 priority, R9 event 7 ignored with select 0
        pulse_int(8'hFE);
        check_req("R9 event7 ignored");
        pulse_clr(); tick(1); check_irq("R5 first");
        do_accept(win_vec());
        pulse_clr(); tick(1); check_irq("R5 second");
        do_accept(win_vec());

        // R11 one cycle after the flag clears
        pulse_clr();
        chk("R11 not yet", int'(irq_valid), 0);
        tick(1); check_irq("R11 signalled");
        do_accept(win_vec());
        w_req(16'h0000); check_req("R3 clear all");

        // R7 edge detection
        set_pins(6'h01); check_req("R7 rising ignored");
        set_pins(6'h00); check_req("R7 falling");
        w_cfg(6'h02, 1'b0);
        set_pins(6'h02); check_req("R7 rising");
        w_req(16'h0000);

        // R8 reconfiguration raises a request
        w_cfg(6'h0A, 1'b0); check_req("R8 no spurious");
        w_cfg(6'h02, 1'b0); check_req("R8 spurious");
        chk("R8 slot4", int'(m_req[4]), 1);
        w_req(16'h0000);

        // R9 shared slot
        w_cfg(6'h02, 1'b1); check_req("R9 select flip");
        w_req(16'h0000);
        pulse_int(8'h80); check_req("R9 event7 selected");
        w_req(16'h0000);
        set_pins(6'h22); set_pins(6'h02); check_req("R9 pin5 ignored");

        // random rounds
        for (int r = 0; r < 40; r++) begin
            int w;
            w_en(16'($urandom));
            pulse_int(8'($urandom));
            if ($urandom % 3 == 0) set_pins(6'($urandom));
            if ($urandom % 4 == 0) w_cfg(6'($urandom), 1'($urandom));
            if ($urandom % 3 == 0) w_req(16'($urandom));
            check_req("R3 random req");
            chk("R2 random masked", int'(irq_valid), 0);
            pulse_clr(); tick(1);
            check_irq("R5 random pick");
            w = win_vec();
            if (w >= 0) begin
                do_accept(w); tick(1);
                chk("R6 random drop", int'(irq_valid), 0);
                check_req("R6 random clear");
            end else begin
                wr(2'd3, 16'h0001);
                m_flag = 1'b1;
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule